// File: doc/BRIEF.md
# Exception Entry Vector and Cause Unit

This block sits beside a processor's control-register file and handles the single cycle in which a pending exception is taken. When the take strobe is raised together with an exception kind, it works out where the handler lives and records the state needed to return. That state is the return address, the branch-delay marker, the exception code and the updated mode bits. It then issues a one-cycle redirect with the new program counter. Normal exceptions, interrupts, non-maskable interrupt and soft reset entry, and debug entry each follow their own rules.

The handler address is a base plus an offset. The base is either a fixed boot-time base or the programmable exception base with its low ten bits cleared. The offset depends on the exception class. Interrupts may be vectored: the slot spacing is programmable, and the vector number either comes from a search for the lowest pending line or is supplied directly by an external interrupt controller. The return address is taken from the current PC with the compressed-ISA flag folded into bit 0. When the faulting instruction sat in a branch delay slot, the return address is moved back onto the branch.

The current status bits arrive as inputs. The block drives the updated status bits as registered outputs, so the surrounding register file can adopt them.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, every output is zero: new PC, redirect, all three return-address registers, exception code, delay marker and the three status bits.
- R2: The kind input is decoded as follows. Values 0 to 31 are normal exceptions whose exception code equals the value. 32 is non-maskable interrupt, 33 is soft reset, 34 is debug single-step and 35 is any other debug event. A take with kind 0 to 35 updates the registers on that clock edge and raises redirect for exactly one cycle. A take with kind 36 to 63 changes no output and raises no redirect.
- R3: For a normal exception, the new PC is base plus offset. The base is 0xBFC00200 when the BEV input is 1. Otherwise it is the exception-base input with bits 9..0 cleared. The offset is 0x180 unless a rule below says otherwise.
- R4: For codes 2 (TLB load) and 3 (TLB store), the offset is 0x000 when the refill input is 1 and the EXL input is 0. In every other case these codes use 0x180.
- R5: For code 0 (interrupt) with vectoring off, the offset is 0x200 when the IV input is 1 and 0x180 when it is 0.
- R6: With internal vectoring on, an interrupt uses offset 0x200 + n × (spacing field × 32). Here n is the index of the lowest set pending line, or 8 when no line is pending. IV has no effect in this mode. Internal vectoring wins over external vectoring when both are on.
- R7: With only external vectoring on, an interrupt uses the 8-bit pending value itself as n in the same formula.
- R8: Code 30 (cache error) uses offset 0x100 when BEV is 1 and 0x20000100 when BEV is 0.
- R9: The resume address is (PC OR isa16), minus 4 when the delay-slot input is 1 and the 16-bit-branch input is 0, and minus 2 when both are 1.
- R10: A normal exception always writes the exception code and sets EXL out. It writes EPC with the resume address and the delay marker with the delay-slot input only when the EXL input is 0; otherwise both hold. ERL and BEV outputs copy their inputs.
- R11: Non-maskable interrupt and soft reset write ErrorEPC with the resume address, set ERL and BEV, copy EXL, clear the delay marker only when EXL is 0, leave the exception code unchanged and jump to 0xBFC00000.
- R12: Debug entry jumps to 0xBFC00480. It writes DEPC with PC OR isa16 for single-step, and with the resume address for other debug kinds. It copies the three status inputs and clears the delay marker only when EXL is 0.
- R13: While take is low, all registered outputs hold and redirect stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Take the exception described by the other inputs this cycle |
| kind_i | input | 6 | Exception kind (R2 encoding) |
| pc_i | input | XLEN | PC of the faulting instruction |
| isa16_i | input | 1 | Core is executing the compressed 16-bit ISA |
| delay_slot_i | input | 1 | Faulting instruction is in a branch delay slot |
| branch16_i | input | 1 | The branch owning the delay slot is 16 bits long |
| exl_i | input | 1 | Current exception-level status bit |
| erl_i | input | 1 | Current error-level status bit |
| bev_i | input | 1 | Current boot-exception-vector status bit |
| ebase_i | input | XLEN | Programmable exception base |
| irq_pend_i | input | IRQ_LINES | Pending interrupt lines or external vector number |
| iv_i | input | 1 | Dedicated interrupt offset select |
| vec_int_i | input | 1 | Internal vectored-interrupt mode |
| vec_ext_i | input | 1 | External-controller vectored mode |
| vec_space_i | input | SPACE_W | Vector spacing field (units of 32 bytes) |
| refill_i | input | 1 | TLB miss had no matching entry (refill case) |
| redirect_o | output | 1 | One-cycle pulse: fetch from new_pc_o |
| new_pc_o | output | XLEN | Handler entry address |
| epc_o | output | XLEN | Exception return address |
| error_epc_o | output | XLEN | Error return address |
| depc_o | output | XLEN | Debug return address |
| exc_code_o | output | 5 | Exception code field |
| bd_o | output | 1 | Delay-slot marker |
| exl_o | output | 1 | Updated exception-level bit |
| erl_o | output | 1 | Updated error-level bit |
| bev_o | output | 1 | Updated boot-vector bit |

## Verification
Every register here is written only in the cycle after a take. A wrong internal value therefore reaches the ports one clock after the take strobe. It shows as a wrong handler address, a wrong return address or a wrong status or code bit, and it stays visible until the next take. The directed scenarios place each offset rule, each delay-slot backup variant and each EXL-gated hold one cycle before a sample point, so a fault in the offset select, the vector search or the EXL gating appears at the very next sample. Sequences such as a delay-slot exception followed by error or debug entry expose a delay marker that was wrongly cleared or wrongly held.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [1:0] {
      GRP_NORMAL,
      GRP_ERROR,
      GRP_DEBUG,
      GRP_NONE
   } exc_group_e;

   localparam logic [5:0] KIND_NMI    = 6'd32;
   localparam logic [5:0] KIND_SRESET = 6'd33;
   localparam logic [5:0] KIND_DSTEP  = 6'd34;
   localparam logic [5:0] KIND_DEBUG  = 6'd35;

   localparam logic [4:0] CODE_INT   = 5'd0;
   localparam logic [4:0] CODE_TLBL  = 5'd2;
   localparam logic [4:0] CODE_TLBS  = 5'd3;
   localparam logic [4:0] CODE_CACHE = 5'd30;

   localparam logic [31:0] OFS_GENERAL   = 32'h0000_0180;
   localparam logic [31:0] OFS_REFILL    = 32'h0000_0000;
   localparam logic [31:0] OFS_IRQ       = 32'h0000_0200;
   localparam logic [31:0] OFS_CERR_BOOT = 32'h0000_0100;
   localparam logic [31:0] OFS_CERR_RUN  = 32'h2000_0100;

   function automatic exc_group_e kind_group(input logic [5:0] kind);
      if (kind < 6'd32)
         return GRP_NORMAL;
      else if (kind == KIND_NMI || kind == KIND_SRESET)
         return GRP_ERROR;
      else if (kind == KIND_DSTEP || kind == KIND_DEBUG)
         return GRP_DEBUG;
      else
         return GRP_NONE;
   endfunction

endpackage

// File: rtl/exc_resume_pc.sv
module exc_resume_pc #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic            isa16_i,
   input  logic            delay_slot_i,
   input  logic            branch16_i,
   output logic [XLEN-1:0] plain_o,
   output logic [XLEN-1:0] resume_o
);
   logic [XLEN-1:0] backup;

   always_comb begin
      plain_o = pc_i | XLEN'(isa16_i);
      if (!delay_slot_i)
         backup = '0;
      else if (branch16_i)
         backup = XLEN'(2);
      else
         backup = XLEN'(4);
      resume_o = plain_o - backup;
   end
endmodule

// File: rtl/exc_irq_vector.sv
module exc_irq_vector #(
   parameter int IRQ_LINES   = 8,
   parameter int SPACE_W     = 6,
   parameter int SPACE_SHIFT = 5,
   parameter bit EXT_VEC_EN  = 1'b1,
   parameter int OFS_W       = 32
) (
   input  logic [IRQ_LINES-1:0] pend_i,
   input  logic [SPACE_W-1:0]   space_i,
   input  logic                 use_int_i,
   input  logic                 use_ext_i,
   output logic                 vec_on_o,
   output logic [OFS_W-1:0]     offset_o
);
   localparam int IDX_W  = IRQ_LINES;
   localparam int STEP_W = SPACE_W + SPACE_SHIFT;
   localparam int PROD_W = IDX_W + STEP_W;

   if (IRQ_LINES < 2) begin : g_bad_lines
      $error("exc_irq_vector: IRQ_LINES must be at least 2");
   end
   if (OFS_W < PROD_W + 1) begin : g_bad_ofs
      $error("exc_irq_vector: OFS_W too narrow for the vector product");
   end

   logic [IDX_W-1:0]  pick [IRQ_LINES+1];
   logic [IDX_W-1:0]  idx;
   logic [STEP_W-1:0] step;
   logic [PROD_W-1:0] prod;
   logic              ext_sel;

   assign pick[IRQ_LINES] = IDX_W'(IRQ_LINES);
   for (genvar g = IRQ_LINES - 1; g >= 0; g--) begin : g_search
      assign pick[g] = pend_i[g] ? IDX_W'(g) : pick[g+1];
   end

   if (EXT_VEC_EN) begin : g_ext
      assign ext_sel = use_ext_i & ~use_int_i;
   end else begin : g_no_ext
      assign ext_sel = 1'b0;
   end

   always_comb begin
      idx      = ext_sel ? pend_i : pick[0];
      step     = {space_i, {SPACE_SHIFT{1'b0}}};
      prod     = PROD_W'(idx) * PROD_W'(step);
      vec_on_o = use_int_i | ext_sel;
      offset_o = OFS_W'(32'h200) + OFS_W'(prod);
   end
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
   import exc_entry_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] BEV_BASE = XLEN'(32'hBFC0_0200)
) (
   input  logic [4:0]      code_i,
   input  logic            bev_i,
   input  logic            exl_i,
   input  logic            refill_i,
   input  logic            iv_i,
   input  logic [XLEN-1:0] ebase_i,
   input  logic            vec_on_i,
   input  logic [XLEN-1:0] vec_offset_i,
   output logic [XLEN-1:0] target_o
);
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   always_comb begin
      base = bev_i ? BEV_BASE : {ebase_i[XLEN-1:10], 10'b0};
      case (code_i)
         CODE_INT: begin
            if (vec_on_i)
               offset = vec_offset_i;
            else if (iv_i)
               offset = XLEN'(OFS_IRQ);
            else
               offset = XLEN'(OFS_GENERAL);
         end
         CODE_TLBL, CODE_TLBS:
            offset = (refill_i && !exl_i) ? XLEN'(OFS_REFILL) : XLEN'(OFS_GENERAL);
         CODE_CACHE:
            offset = bev_i ? XLEN'(OFS_CERR_BOOT) : XLEN'(OFS_CERR_RUN);
         default:
            offset = XLEN'(OFS_GENERAL);
      endcase
      target_o = base + offset;
   end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              IRQ_LINES   = 8,
   parameter int              SPACE_W     = 6,
   parameter int              SPACE_SHIFT = 5,
   parameter bit              EXT_VEC_EN  = 1'b1,
   parameter logic [XLEN-1:0] BEV_BASE    = XLEN'(32'hBFC0_0200),
   parameter logic [XLEN-1:0] ERR_VEC     = XLEN'(32'hBFC0_0000),
   parameter logic [XLEN-1:0] DBG_VEC     = XLEN'(32'hBFC0_0480)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 take_i,
   input  logic [5:0]           kind_i,
   input  logic [XLEN-1:0]      pc_i,
   input  logic                 isa16_i,
   input  logic                 delay_slot_i,
   input  logic                 branch16_i,
   input  logic                 exl_i,
   input  logic                 erl_i,
   input  logic                 bev_i,
   input  logic [XLEN-1:0]      ebase_i,
   input  logic [IRQ_LINES-1:0] irq_pend_i,
   input  logic                 iv_i,
   input  logic                 vec_int_i,
   input  logic                 vec_ext_i,
   input  logic [SPACE_W-1:0]   vec_space_i,
   input  logic                 refill_i,
   output logic                 redirect_o,
   output logic [XLEN-1:0]      new_pc_o,
   output logic [XLEN-1:0]      epc_o,
   output logic [XLEN-1:0]      error_epc_o,
   output logic [XLEN-1:0]      depc_o,
   output logic [4:0]           exc_code_o,
   output logic                 bd_o,
   output logic                 exl_o,
   output logic                 erl_o,
   output logic                 bev_o
);
   if (XLEN < 32) begin : g_bad_xlen
      $error("exc_entry_unit: XLEN must be at least 32");
   end

   exc_group_e      grp;
   logic [XLEN-1:0] plain_pc;
   logic [XLEN-1:0] resume_pc;
   logic            vec_on;
   logic [XLEN-1:0] vec_offset;
   logic [XLEN-1:0] target;

   assign grp = kind_group(kind_i);

   exc_resume_pc #(.XLEN(XLEN)) u_resume (
      .pc_i         (pc_i),
      .isa16_i      (isa16_i),
      .delay_slot_i (delay_slot_i),
      .branch16_i   (branch16_i),
      .plain_o      (plain_pc),
      .resume_o     (resume_pc)
   );

   exc_irq_vector #(
      .IRQ_LINES   (IRQ_LINES),
      .SPACE_W     (SPACE_W),
      .SPACE_SHIFT (SPACE_SHIFT),
      .EXT_VEC_EN  (EXT_VEC_EN),
      .OFS_W       (XLEN)
   ) u_vector (
      .pend_i    (irq_pend_i),
      .space_i   (vec_space_i),
      .use_int_i (vec_int_i),
      .use_ext_i (vec_ext_i),
      .vec_on_o  (vec_on),
      .offset_o  (vec_offset)
   );

   exc_target_calc #(
      .XLEN     (XLEN),
      .BEV_BASE (BEV_BASE)
   ) u_target (
      .code_i       (kind_i[4:0]),
      .bev_i        (bev_i),
      .exl_i        (exl_i),
      .refill_i     (refill_i),
      .iv_i         (iv_i),
      .ebase_i      (ebase_i),
      .vec_on_i     (vec_on),
      .vec_offset_i (vec_offset),
      .target_o     (target)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         redirect_o  <= 1'b0;
         new_pc_o    <= '0;
         epc_o       <= '0;
         error_epc_o <= '0;
         depc_o      <= '0;
         exc_code_o  <= '0;
         bd_o        <= 1'b0;
         exl_o       <= 1'b0;
         erl_o       <= 1'b0;
         bev_o       <= 1'b0;
      end else begin
         redirect_o <= 1'b0;
         if (take_i) begin
            case (grp)
               GRP_NORMAL: begin
                  redirect_o <= 1'b1;
                  new_pc_o   <= target;
                  exc_code_o <= kind_i[4:0];
                  if (!exl_i) begin
                     epc_o <= resume_pc;
                     bd_o  <= delay_slot_i;
                  end
                  exl_o <= 1'b1;
                  erl_o <= erl_i;
                  bev_o <= bev_i;
               end
               GRP_ERROR: begin
                  redirect_o  <= 1'b1;
                  new_pc_o    <= ERR_VEC;
                  error_epc_o <= resume_pc;
                  if (!exl_i)
                     bd_o <= 1'b0;
                  exl_o <= exl_i;
                  erl_o <= 1'b1;
                  bev_o <= 1'b1;
               end
               GRP_DEBUG: begin
                  redirect_o <= 1'b1;
                  new_pc_o   <= DBG_VEC;
                  depc_o     <= (kind_i == KIND_DSTEP) ? plain_pc : resume_pc;
                  if (!exl_i)
                     bd_o <= 1'b0;
                  exl_o <= exl_i;
                  erl_o <= erl_i;
                  bev_o <= bev_i;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
   parameter int              XLEN    = 32,
   parameter logic [XLEN-1:0] ERR_VEC = XLEN'(32'hBFC0_0000),
   parameter logic [XLEN-1:0] DBG_VEC = XLEN'(32'hBFC0_0480)
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            take_i,
   input logic [5:0]      kind_i,
   input logic            exl_i,
   input logic            redirect_o,
   input logic [XLEN-1:0] new_pc_o,
   input logic [XLEN-1:0] epc_o,
   input logic [XLEN-1:0] error_epc_o,
   input logic [XLEN-1:0] depc_o,
   input logic            bd_o,
   input logic            exl_o,
   input logic            erl_o,
   input logic            bev_o
);
   assert_redirect_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redirect_o |-> ($past(take_i) && $past(kind_i) < 6'd36));

   assert_exl_raised_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && kind_i < 6'd32) |=> exl_o);

   assert_epc_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && kind_i < 6'd32 && exl_i) |=> ($stable(epc_o) && $stable(bd_o)));

   assert_error_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && (kind_i == 6'd32 || kind_i == 6'd33))
         |=> (erl_o && bev_o && redirect_o && new_pc_o == ERR_VEC));

   assert_debug_entry_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && (kind_i == 6'd34 || kind_i == 6'd35))
         |=> (redirect_o && new_pc_o == DBG_VEC));

   assert_idle_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take_i |=> (!redirect_o && $stable(epc_o) && $stable(error_epc_o)
                   && $stable(depc_o) && $stable(new_pc_o)));
endmodule

bind exc_entry_unit exc_entry_checker #(
   .XLEN    (XLEN),
   .ERR_VEC (ERR_VEC),
   .DBG_VEC (DBG_VEC)
) u_exc_entry_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .take_i      (take_i),
   .kind_i      (kind_i),
   .exl_i       (exl_i),
   .redirect_o  (redirect_o),
   .new_pc_o    (new_pc_o),
   .epc_o       (epc_o),
   .error_epc_o (error_epc_o),
   .depc_o      (depc_o),
   .bd_o        (bd_o),
   .exl_o       (exl_o),
   .erl_o       (erl_o),
   .bev_o       (bev_o)
);

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take = 1'b0;
   logic [5:0]  kind = '0;
   logic [31:0] pc = '0;
   logic        isa16 = 1'b0, dslot = 1'b0, br16 = 1'b0;
   logic        exl = 1'b0, erl = 1'b0, bev = 1'b0;
   logic [31:0] ebase = '0;
   logic [7:0]  pend = '0;
   logic        iv = 1'b0, vint = 1'b0, vext = 1'b0, refill = 1'b0;
   logic [5:0]  space = '0;

   logic        redirect;
   logic [31:0] new_pc, epc, eepc, depc;
   logic [4:0]  code;
   logic        bd, exl_q, erl_q, bev_q;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   exc_entry_unit dut (
      .clk_i(clk), .rst_ni(rst_n), .take_i(take), .kind_i(kind), .pc_i(pc),
      .isa16_i(isa16), .delay_slot_i(dslot), .branch16_i(br16),
      .exl_i(exl), .erl_i(erl), .bev_i(bev), .ebase_i(ebase),
      .irq_pend_i(pend), .iv_i(iv), .vec_int_i(vint), .vec_ext_i(vext),
      .vec_space_i(space), .refill_i(refill),
      .redirect_o(redirect), .new_pc_o(new_pc), .epc_o(epc),
      .error_epc_o(eepc), .depc_o(depc), .exc_code_o(code), .bd_o(bd),
      .exl_o(exl_q), .erl_o(erl_q), .bev_o(bev_q)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic defaults();
      exl = 0; erl = 0; bev = 0; ebase = 32'h8000_0000; pc = 32'h0040_1000;
      isa16 = 0; dslot = 0; br16 = 0; pend = 0; iv = 0; vint = 0; vext = 0;
      space = 0; refill = 0;
   endtask

   task automatic fire(input logic [5:0] k);
      @(negedge clk);
      kind = k; take = 1'b1;
      @(negedge clk);
      take = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "new_pc", new_pc, 0);
      chk("R1", "redirect", 32'(redirect), 0);
      chk("R1", "epc", epc, 0);
      chk("R1", "error_epc", eepc, 0);
      chk("R1", "depc", depc, 0);
      chk("R1", "code/bd/status", {code, bd, exl_q, erl_q, bev_q}, 0);
   endtask

   task automatic t_default_entry();
      defaults();
      fire(6'd8);
      chk("R3", "syscall pc", new_pc, 32'h8000_0180);
      chk("R2", "redirect pulse", 32'(redirect), 1);
      chk("R10", "epc", epc, 32'h0040_1000);
      chk("R10", "code", 32'(code), 8);
      chk("R10", "exl set", 32'(exl_q), 1);
      @(negedge clk);
      chk("R2", "redirect drops", 32'(redirect), 0);
      ebase = 32'h9000_03FF;
      fire(6'd12);
      chk("R3", "ebase low bits cleared", new_pc, 32'h9000_0180);
      bev = 1;
      fire(6'd12);
      chk("R3", "boot base", new_pc, 32'hBFC0_0380);
      chk("R10", "bev copied", 32'(bev_q), 1);
   endtask

   task automatic t_refill();
      defaults();
      refill = 1; pc = 32'h0040_2000;
      fire(6'd2);
      chk("R4", "load refill", new_pc, 32'h8000_0000);
      fire(6'd3);
      chk("R4", "store refill", new_pc, 32'h8000_0000);
      exl = 1; pc = 32'h0040_3000; dslot = 1;
      fire(6'd3);
      chk("R4", "refill under exl", new_pc, 32'h8000_0180);
      chk("R10", "epc held under exl", epc, 32'h0040_2000);
      chk("R10", "bd held under exl", 32'(bd), 0);
      chk("R10", "code written under exl", 32'(code), 3);
      exl = 0; refill = 0; dslot = 0;
      fire(6'd2);
      chk("R4", "tlb miss without refill", new_pc, 32'h8000_0180);
   endtask

   task automatic t_resume();
      defaults();
      pc = 32'h0040_2008; dslot = 1;
      fire(6'd10);
      chk("R9", "32-bit branch backup", epc, 32'h0040_2004);
      chk("R10", "bd from delay slot", 32'(bd), 1);
      isa16 = 1; br16 = 1;
      fire(6'd10);
      chk("R9", "16-bit branch backup", epc, 32'h0040_2007);
      dslot = 0; br16 = 0;
      fire(6'd10);
      chk("R9", "isa bit folded", epc, 32'h0040_2009);
   endtask

   task automatic t_interrupt();
      defaults();
      fire(6'd0);
      chk("R5", "general offset", new_pc, 32'h8000_0180);
      iv = 1;
      fire(6'd0);
      chk("R5", "iv offset", new_pc, 32'h8000_0200);
      chk("R5", "code", 32'(code), 0);
   endtask

   task automatic t_vec_internal();
      defaults();
      vint = 1; iv = 1; space = 6'd1; pend = 8'b0010_1000;
      fire(6'd0);
      chk("R6", "lowest line 3", new_pc, 32'h8000_0260);
      space = 6'd63; pend = 8'h80;
      fire(6'd0);
      chk("R6", "line 7 max spacing", new_pc, 32'h8000_3920);
      space = 6'd1; pend = 8'h00;
      fire(6'd0);
      chk("R6", "none pending", new_pc, 32'h8000_0300);
      vext = 1; pend = 8'h05;
      fire(6'd0);
      chk("R6", "internal wins", new_pc, 32'h8000_0200);
   endtask

   task automatic t_vec_external();
      defaults();
      vext = 1; space = 6'd2; pend = 8'h05;
      fire(6'd0);
      chk("R7", "external vector 5", new_pc, 32'h8000_0340);
      pend = 8'h00;
      fire(6'd0);
      chk("R7", "external vector 0", new_pc, 32'h8000_0200);
   endtask

   task automatic t_cache();
      defaults();
      fire(6'd30);
      chk("R8", "cache run base", new_pc, 32'hA000_0100);
      chk("R8", "code", 32'(code), 30);
      bev = 1;
      fire(6'd30);
      chk("R8", "cache boot", new_pc, 32'hBFC0_0300);
   endtask

   task automatic t_error_entry();
      defaults();
      dslot = 1; pc = 32'h0050_0004;
      fire(6'd8);
      chk("R11", "setup bd", 32'(bd), 1);
      exl = 1; dslot = 0; pc = 32'h0050_0010;
      fire(6'd32);
      chk("R11", "nmi pc", new_pc, 32'hBFC0_0000);
      chk("R11", "nmi error_epc", eepc, 32'h0050_0010);
      chk("R11", "erl/bev/exl", {29'd0, erl_q, bev_q, exl_q}, 32'h7);
      chk("R11", "bd held under exl", 32'(bd), 1);
      chk("R11", "code unchanged", 32'(code), 8);
      exl = 0; dslot = 1; pc = 32'h0050_0020;
      fire(6'd33);
      chk("R11", "soft reset error_epc", eepc, 32'h0050_001C);
      chk("R11", "bd cleared", 32'(bd), 0);
      chk("R11", "exl copied", 32'(exl_q), 0);
      chk("R11", "soft reset pc", new_pc, 32'hBFC0_0000);
   endtask

   task automatic t_debug_entry();
      defaults();
      dslot = 1; pc = 32'h0060_0004;
      fire(6'd9);
      exl = 1; isa16 = 1; pc = 32'h0060_0010; erl = 1;
      fire(6'd34);
      chk("R12", "single-step depc", depc, 32'h0060_0011);
      chk("R12", "debug pc", new_pc, 32'hBFC0_0480);
      chk("R12", "bd held under exl", 32'(bd), 1);
      chk("R12", "status copied", {29'd0, exl_q, erl_q, bev_q}, 32'h6);
      exl = 0; erl = 0; isa16 = 0;
      fire(6'd35);
      chk("R12", "debug depc backed up", depc, 32'h0060_000C);
      chk("R12", "bd cleared", 32'(bd), 0);
      chk("R12", "code unchanged", 32'(code), 9);
   endtask

   task automatic t_ignore_and_hold();
      logic [31:0] pc_before, epc_before;
      defaults();
      fire(6'd4);
      pc_before = new_pc; epc_before = epc;
      pc = 32'h0070_0000;
      fire(6'd40);
      chk("R2", "no redirect for kind 40", 32'(redirect), 0);
      chk("R2", "new_pc kept", new_pc, pc_before);
      chk("R2", "epc kept", epc, epc_before);
      chk("R2", "code kept", 32'(code), 4);
      kind = 6'd8; pc = 32'h0071_0000; exl = 0;
      repeat (3) @(negedge clk);
      chk("R13", "idle redirect", 32'(redirect), 0);
      chk("R13", "idle epc", epc, epc_before);
      chk("R13", "idle new_pc", new_pc, pc_before);
   endtask

   initial begin
      defaults();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_entry();
      t_refill();
      t_resume();
      t_interrupt();
      t_vec_internal();
      t_vec_external();
      t_cache();
      t_error_entry();
      t_debug_entry();
      t_ignore_and_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule